// File: doc/BRIEF.md
# Random Word Source Control and Fault Manager

This block is the control and status logic for a 32-bit true random word source. Software sets an enable bit and an interrupt-enable bit. The block then waits a fixed warm-up interval before it lets the conditioning logic deliver words. It captures each valid word into a holding register and raises a data-ready flag. It also handles the two fault conditions of the source. A seed (noise) fault halts generation, discards any pending word and needs an explicit recovery sequence from software. A clock fault only pauses generation while it lasts.

The noise source and the conditioning logic sit outside this block. The conditioning logic watches `gen_active` and presents words on `word_in` with a one-cycle `word_vld` strobe. A read of the data register appears as a one-cycle `dr_rd` strobe. The clear inputs model software writing a zero to the corresponding interrupt flag.

Top module: `rng_ctrl_mgr`

## Requirements
- R1: After reset, `drdy`, `seed_stat`, `seed_flag`, `clk_flag`, `irq` and `gen_active` are all 0.
- R2: After `en` is sampled high from the disabled state, `gen_active` rises exactly 46 clock edges later. A `word_vld` that arrives before then is ignored, and `drdy` stays 0.
- R3: While `gen_active` is 1 and `clk_err` is 0, a `word_vld` pulse loads `word_in` into `data_o` and sets `drdy` on the next edge.
- R4: A `dr_rd` pulse clears `drdy`. `drdy` stays 0 until the next accepted word.
- R5: Driving `en` to 0 stops generation (`gen_active` goes to 0) but leaves `drdy` and `data_o` unchanged. Words that arrive while disabled are ignored.
- R6: A `seed_err` pulse while the block is warming up or running sets `seed_stat` and `seed_flag` to 1, clears `drdy` and drops `gen_active`.
- R7: If `en` is toggled while `seed_flag` is still 1, `seed_stat` stays 1 and generation stays halted. Recovery works as follows: first pulse `seed_flag_clr`, then drive `en` to 0. This clears `seed_stat`. Then drive `en` back to 1, which restarts the 46-cycle warm-up.
- R8: While `clk_err` is 1, the warm-up count pauses, words are ignored, and `drdy` and `data_o` are held. `clk_flag` is set while `clk_err` is 1 and is cleared by `clk_flag_clr` once `clk_err` is 0.
- R9: `irq` equals `ie AND (drdy OR seed_flag OR clk_flag)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable bit |
| ie | input | 1 | Shared interrupt enable |
| seed_err | input | 1 | Raw noise-source fault indication |
| clk_err | input | 1 | Clock-checker fault status |
| word_vld | input | 1 | Conditioned word valid strobe |
| word_in | input | 32 | Conditioned random word |
| dr_rd | input | 1 | Data register read strobe |
| seed_flag_clr | input | 1 | Software clear of the seed fault interrupt flag |
| clk_flag_clr | input | 1 | Software clear of the clock fault interrupt flag |
| gen_active | output | 1 | Conditioning logic may deliver words |
| data_o | output | 32 | Held random word |
| drdy | output | 1 | Data ready flag |
| seed_stat | output | 1 | Seed fault status |
| seed_flag | output | 1 | Seed fault interrupt flag |
| clk_flag | output | 1 | Clock fault interrupt flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Most state faults show up at the ports within one edge. A wrong state register appears at once on `gen_active`. A warm-up counter that is off by one moves the rise of `gen_active` to edge 45 or 47, so the check brackets edge 46 on both sides. A seed status that clears at the wrong moment would let `gen_active` return after an early toggle of `en`, so the bench waits well past a full warm-up to prove the block stays halted. A counter that keeps running during a clock fault shifts the warm-up end by the length of the fault.

// File: rtl/rng_ctrl_mgr.sv
module rng_ctrl_mgr #(
  parameter int DW          = 32,
  parameter int STARTUP_CYC = 46
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ie,
  input  logic          seed_err,
  input  logic          clk_err,
  input  logic          word_vld,
  input  logic [DW-1:0] word_in,
  input  logic          dr_rd,
  input  logic          seed_flag_clr,
  input  logic          clk_flag_clr,
  output logic          gen_active,
  output logic [DW-1:0] data_o,
  output logic          drdy,
  output logic          seed_stat,
  output logic          seed_flag,
  output logic          clk_flag,
  output logic          irq
);
  localparam int CW = $clog2(STARTUP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

  typedef enum logic [1:0] {OFF, WARM, RUN, HALT} st_t;
  st_t st, st_nx;
  logic [CW-1:0] cnt;

  wire live     = en && (st == WARM || st == RUN);
  wire seed_hit = live && seed_err;
  wire accept   = en && st == RUN && !clk_err && !seed_err && word_vld;

  assign gen_active = st == RUN;
  assign irq = ie && (drdy || seed_flag || clk_flag);

  always_comb begin
    st_nx = st;
    if (!en) st_nx = OFF;
    else begin
      case (st)
        OFF:  st_nx = seed_stat ? HALT : WARM;
        WARM: if (seed_hit) st_nx = HALT;
              else if (!clk_err && cnt == LAST) st_nx = RUN;
        RUN:  if (seed_hit) st_nx = HALT;
        default: st_nx = HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= OFF;
      cnt       <= '0;
      drdy      <= 1'b0;
      data_o    <= '0;
      seed_stat <= 1'b0;
      seed_flag <= 1'b0;
      clk_flag  <= 1'b0;
    end else begin
      st <= st_nx;
      if (st != WARM) cnt <= '0;
      else if (!clk_err) cnt <= cnt + 1'b1;

      if (seed_hit) drdy <= 1'b0;
      else if (accept) drdy <= 1'b1;
      else if (dr_rd) drdy <= 1'b0;
      if (accept) data_o <= word_in;

      if (seed_hit) seed_stat <= 1'b1;
      else if (!en && !seed_flag) seed_stat <= 1'b0;
      if (seed_hit) seed_flag <= 1'b1;
      else if (seed_flag_clr) seed_flag <= 1'b0;

      if (clk_err) clk_flag <= 1'b1;
      else if (clk_flag_clr) clk_flag <= 1'b0;
    end
  end

  assert_warmup_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && $past(st) == WARM) |-> $past(cnt) == LAST);

  assert_drdy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy) |-> $past(word_vld));

  assert_drdy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy) |-> $past(dr_rd || seed_err));

  assert_disable_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gen_active);

  assert_seed_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seed_stat) |-> seed_flag);

  assert_seed_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_stat |-> !gen_active);

  assert_clk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_err) && !$past(dr_rd) && !$past(seed_err) |-> $stable(data_o) && $stable(drdy));
endmodule

// File: tb/rng_ctrl_mgr_bench.sv
module rng_ctrl_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WORDS [4] = '{32'hDEAD_BEEF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h5A5A_A5A5};

  logic clk = 0, rst_n = 0, en = 0, ie = 0, seed_err = 0, clk_err = 0;
  logic word_vld = 0, dr_rd = 0, seed_flag_clr = 0, clk_flag_clr = 0;
  logic [31:0] word_in = '0;
  logic gen_active, drdy, seed_stat, seed_flag, clk_flag, irq;
  logic [31:0] data_o;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_ctrl_mgr u_rng_ctrl_mgr (
    .clk(clk), .rst_n(rst_n), .en(en), .ie(ie), .seed_err(seed_err), .clk_err(clk_err),
    .word_vld(word_vld), .word_in(word_in), .dr_rd(dr_rd), .seed_flag_clr(seed_flag_clr),
    .clk_flag_clr(clk_flag_clr), .gen_active(gen_active), .data_o(data_o), .drdy(drdy),
    .seed_stat(seed_stat), .seed_flag(seed_flag), .clk_flag(clk_flag), .irq(irq));

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic feed(input logic [31:0] w);
    word_in = w; word_vld = 1; tick(); word_vld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] held;
    tick(3);
    chk("R1 drdy", drdy, 0); chk("R1 seed_stat", seed_stat, 0);
    chk("R1 seed_flag", seed_flag, 0); chk("R1 clk_flag", clk_flag, 0);
    chk("R1 irq", irq, 0); chk("R1 gen_active", gen_active, 0);
    rst_n = 1; tick();

    // R2: warm-up of 46 edges, early word ignored
    en = 1; tick();
    feed(32'h1234_5678);
    chk("R2 early word drdy", drdy, 0);
    tick(44); chk("R2 gen at 45", gen_active, 0);
    tick();   chk("R2 gen at 46", gen_active, 1);

    // R3/R4/R9: table walk
    ie = 1;
    for (int i = 0; i < 4; i++) begin
      feed(WORDS[i]);
      chk("R3 drdy", drdy, 1); chk("R3 data", data_o, WORDS[i]); chk("R9 irq on drdy", irq, 1);
      dr_rd = 1; tick(); dr_rd = 0;
      chk("R4 drdy cleared", drdy, 0); chk("R9 irq idle", irq, 0);
    end
    tick(5); chk("R4 drdy stays low", drdy, 0);

    ie = 0; feed(32'hCAFE_0001); #1;
    chk("R9 irq masked", irq, 0);
    ie = 1; #1; chk("R9 irq unmasked", irq, 1);

    // R5: disable keeps data
    tick(); en = 0; tick();
    chk("R5 gen off", gen_active, 0); chk("R5 drdy kept", drdy, 1); chk("R5 data kept", data_o, 32'hCAFE_0001);
    feed(32'h0BAD_0BAD);
    chk("R5 word ignored", data_o, 32'hCAFE_0001);
    dr_rd = 1; tick(); dr_rd = 0;

    // R8: clock fault pauses warm-up
    en = 1; tick();
    tick(10);
    clk_err = 1; tick(20);
    chk("R8 clk_flag set", clk_flag, 1); chk("R8 gen paused", gen_active, 0); chk("R9 irq clk", irq, 1);
    clk_err = 0; tick(35); chk("R8 warm-up paused at 45", gen_active, 0);
    tick(); chk("R8 warm-up end at 46", gen_active, 1);
    feed(32'h7777_0000);
    clk_err = 1; tick();
    feed(32'h8888_1111);
    chk("R8 data held", data_o, 32'h7777_0000); chk("R8 drdy held", drdy, 1);
    clk_err = 0; clk_flag_clr = 1; tick(); clk_flag_clr = 0; tick();
    chk("R8 clk_flag cleared", clk_flag, 0);

    // R6: seed fault
    held = data_o;
    seed_err = 1; tick(); seed_err = 0;
    chk("R6 seed_stat", seed_stat, 1); chk("R6 seed_flag", seed_flag, 1);
    chk("R6 drdy dropped", drdy, 0); chk("R6 gen off", gen_active, 0); chk("R9 irq seed", irq, 1);

    // R7: toggle before clear stays halted
    en = 0; tick(2); en = 1; tick(60);
    chk("R7 still halted", gen_active, 0); chk("R7 stat kept", seed_stat, 1);
    seed_flag_clr = 1; tick(); seed_flag_clr = 0;
    chk("R7 flag cleared", seed_flag, 0); chk("R7 stat until toggle", seed_stat, 1);
    en = 0; tick();
    chk("R7 stat cleared", seed_stat, 0);
    en = 1; tick();
    tick(45); chk("R7 restart at 45", gen_active, 0);
    tick();   chk("R7 restart at 46", gen_active, 1);
    feed(32'h4242_4242);
    chk("R7 new word", data_o, 32'h4242_4242);
    chk("R6 old word replaced", data_o != held, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule